// File: doc/BRIEF.md
# Three-Phase Commutation and Brake Logic

This block turns three digital Hall-sensor levels into the six gate-drive enables of a three-phase bridge: one high-side and one low-side enable per phase (U, V, W). Each of the six legal Hall codes picks exactly one phase whose high-side switch conducts and one other phase whose low-side switch conducts. A direction bit reverses rotation, a PWM waveform chops the high side only, and a current-limit trip blanks the high side until the carrier's next rising edge. A brake request shorts the motor through all three high-side switches. A stop request or a drive-disable request turns every switch off.

All inputs are taken as already synchronous to `clk`. Every enable is registered, so the outputs respond to an input in the cycle after the clock edge that samples it. Bit 0 of each three-bit enable vector is phase U, bit 1 is phase V and bit 2 is phase W. The `stop` and `brake` inputs are active high, so a floating pin pulled high means stopped and braking.

When a phase's high-side command goes away and the same phase is then selected for the low side, a dead-time guard holds that low-side switch off for `DEAD_CYC` clocks.

Top module: `bldc_commutator`

## Requirements
- R1: While `rst_n` is low at a clock edge, all six enables are 0 after that edge.
- R2: When `stop` is 1 and `drv_off` is 0, all six enables are 0 in the next cycle.
- R3: When `drv_off` is 1, all six enables are 0 in the next cycle, whatever the other inputs are.
- R4: With `dir_rev` = 0 and running (`stop`, `brake`, `drv_off` all 0), the Hall code {hall[2],hall[1],hall[0]} selects (high, low) as follows: 001→(U,V), 011→(U,W), 010→(V,W), 110→(V,U), 100→(W,U), 101→(W,V).
- R5: With `dir_rev` = 1, the bitwise complement of the Hall code is looked up in the R4 table.
- R6: Running with Hall code 000 or 111 (after any direction complement), all six enables are 0.
- R7: When `brake` is 1 and `stop` and `drv_off` are 0, `hi_en` = 111 and `lo_en` = 000 in the next cycle, regardless of `pwm`, `ilim_trip` or the Hall code.
- R8: While running, the selected high-side enable follows `pwm` (off when `pwm` is 0), and the selected low-side enable stays on continuously.
- R9: A sampled `ilim_trip` of 1 forces `hi_en` to 0 in the next cycle and keeps it 0 until a cycle in which `pwm` is sampled 1 after having been sampled 0. Brake ignores the trip, and `lo_en` is not affected.
- R10: A phase's low-side enable stays 0 for the first `DEAD_CYC` sampled cycles after the last cycle in which that phase's high side was commanded. Brake counts as commanding all three high sides.
- R11: At no time are the high-side and low-side enables of the same phase both 1, and at most one low-side enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hall | input | 3 | Hall levels: bit 0 sensor 1, bit 1 sensor 2, bit 2 sensor 3 |
| dir_rev | input | 1 | 0 forward, 1 reverse |
| brake | input | 1 | 1 requests short braking |
| stop | input | 1 | 1 stops (all off), 0 runs |
| pwm | input | 1 | PWM carrier output, gates the high side |
| ilim_trip | input | 1 | Current-limit trip |
| drv_off | input | 1 | Fault drive-disable request |
| hi_en | output | 3 | High-side enables: bit 0 U, bit 1 V, bit 2 W |
| lo_en | output | 3 | Low-side enables: bit 0 U, bit 1 V, bit 2 W |

## Verification
Only three pieces of hidden state exist: a per-phase dead-time age, a blanking flag and the last PWM sample. A wrong dead-time age would show as a low-side enable that comes on early or stays off too long within `DEAD_CYC` cycles of a commutation step or a brake release. A stuck blanking flag would hold the high side dark across PWM rising edges, or let it chop through a trip, and this would be visible within one carrier period. Because the reference model is compared on every clock, each of these faults is reported in the first cycle it reaches the ports.

// File: rtl/bldc_pkg.sv
// Shared types for the commutation block.
// Phase vectors use bit 0 = U, bit 1 = V, bit 2 = W throughout.
package bldc_pkg;
    typedef logic [2:0] phase_vec_t;

    localparam phase_vec_t PH_NONE = 3'b000;
    localparam phase_vec_t PH_U    = 3'b001;
    localparam phase_vec_t PH_V    = 3'b010;
    localparam phase_vec_t PH_W    = 3'b100;
    localparam phase_vec_t PH_ALL  = 3'b111;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_BRAKE = 2'd1,
        MODE_RUN   = 2'd2
    } drive_mode_t;
endpackage

// File: rtl/comm_decode.sv
// Combinational Hall-to-phase decoder.
// Assumes hall is synchronous and glitch-free. In reverse, the complemented
// code is looked up in the forward table. Codes 000 and 111 give no selection.
module comm_decode
    import bldc_pkg::*;
(
    input  logic [2:0]  hall,
    input  logic        dir_rev,
    output phase_vec_t  hi_sel,
    output phase_vec_t  lo_sel,
    output logic        code_ok
);
    logic [2:0] code;

    // Apply direction by complementing the sensor pattern.
    always_comb code = dir_rev ? ~hall : hall;

    // Forward step table: one sourcing phase, one sinking phase.
    always_comb begin
        hi_sel  = PH_NONE;
        lo_sel  = PH_NONE;
        code_ok = 1'b1;
        case (code)
            3'b001: begin hi_sel = PH_U; lo_sel = PH_V; end
            3'b011: begin hi_sel = PH_U; lo_sel = PH_W; end
            3'b010: begin hi_sel = PH_V; lo_sel = PH_W; end
            3'b110: begin hi_sel = PH_V; lo_sel = PH_U; end
            3'b100: begin hi_sel = PH_W; lo_sel = PH_U; end
            3'b101: begin hi_sel = PH_W; lo_sel = PH_V; end
            default: code_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/trip_blanker.sv
// Current-limit blanking against the PWM carrier.
// A trip closes the high-side gate at once. The gate stays closed until
// pwm is sampled high after having been sampled low. Assumes pwm and trip
// are synchronous to clk.
module trip_blanker (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm,
    input  logic trip,
    output logic gate_open
);
    logic pwm_q;
    logic blank_q;
    logic rise;
    logic blank_now;

    // Carrier rising edge and the blanking seen in the current cycle.
    always_comb begin
        rise      = pwm & ~pwm_q;
        blank_now = trip | (blank_q & ~rise);
        gate_open = pwm & ~blank_now;
    end

    // Hold the previous carrier level and the blanking flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_q   <= 1'b0;
            blank_q <= 1'b0;
        end else begin
            pwm_q   <= pwm;
            blank_q <= blank_now;
        end
    end

    // R9: with no trip, a carrier rising edge reopens the gate.
    a_r9_rise_reopens: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && !pwm_q && !trip) |-> gate_open);
endmodule

// File: rtl/dead_guard.sv
// Per-phase dead-time guard.
// Each phase keeps an age counter that is reloaded while its high side is
// commanded and counts down otherwise. The low side of a phase is allowed
// only when its counter is zero. DEAD_CYC = 0 removes the guard.
module dead_guard
    import bldc_pkg::*;
#(
    parameter int DEAD_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  phase_vec_t cmd_hi,
    output phase_vec_t lo_ok
);
    localparam int AW = (DEAD_CYC < 1) ? 1 : $clog2(DEAD_CYC + 1);

    for (genvar p = 0; p < 3; p++) begin : g_phase
        if (DEAD_CYC == 0) begin : g_none
            assign lo_ok[p] = 1'b1;
        end else begin : g_cnt
            logic [AW-1:0] age_q;

            // Reload on a high-side command, otherwise count down to zero.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    age_q <= '0;
                else if (cmd_hi[p])
                    age_q <= AW'(DEAD_CYC);
                else if (age_q != '0)
                    age_q <= age_q - AW'(1);
            end

            assign lo_ok[p] = (age_q == '0);

            // R10: the cycle after a high-side command, the low side is locked.
            a_r10_low_locked: assert property (@(posedge clk) disable iff (!rst_n)
                cmd_hi[p] |=> !lo_ok[p]);
        end
    end
endmodule

// File: rtl/bldc_commutator.sv
// Three-phase commutation and brake logic.
// Decodes Hall levels into six registered gate enables. Priority: drive
// disable, then stop, then brake, then Hall commutation. The high side is
// chopped by pwm and blanked by current-limit trips. The low side is continuous
// apart from the dead-time guard. All inputs are assumed synchronous to clk.
module bldc_commutator
    import bldc_pkg::*;
#(
    parameter int DEAD_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hall,
    input  logic       dir_rev,
    input  logic       brake,
    input  logic       stop,
    input  logic       pwm,
    input  logic       ilim_trip,
    input  logic       drv_off,
    output logic [2:0] hi_en,
    output logic [2:0] lo_en
);
    drive_mode_t mode;
    phase_vec_t  dec_hi, dec_lo;
    logic        dec_ok;
    logic        gate_open;
    phase_vec_t  cmd_hi, cmd_lo;
    phase_vec_t  lo_ok;
    phase_vec_t  hi_next, lo_next;

    comm_decode u_dec (
        .hall    (hall),
        .dir_rev (dir_rev),
        .hi_sel  (dec_hi),
        .lo_sel  (dec_lo),
        .code_ok (dec_ok)
    );

    trip_blanker u_blank (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwm       (pwm),
        .trip      (ilim_trip),
        .gate_open (gate_open)
    );

    dead_guard #(.DEAD_CYC(DEAD_CYC)) u_dead (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_hi (cmd_hi),
        .lo_ok  (lo_ok)
    );

    // Resolve the operating mode by priority.
    always_comb begin
        if (drv_off || stop) mode = MODE_OFF;
        else if (brake)      mode = MODE_BRAKE;
        else                 mode = MODE_RUN;
    end

    // Switch commands before PWM gating and dead time.
    always_comb begin
        unique case (mode)
            MODE_BRAKE: begin cmd_hi = PH_ALL; cmd_lo = PH_NONE; end
            MODE_RUN:   begin cmd_hi = dec_hi; cmd_lo = dec_lo;  end
            default:    begin cmd_hi = PH_NONE; cmd_lo = PH_NONE; end
        endcase
    end

    // Apply chopping to the high side and dead time to the low side.
    always_comb begin
        hi_next = (mode == MODE_BRAKE) ? cmd_hi : (cmd_hi & {3{gate_open}});
        lo_next = cmd_lo & lo_ok;
    end

    // Register the six enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_en <= '0;
            lo_en <= '0;
        end else begin
            hi_en <= hi_next;
            lo_en <= lo_next;
        end
    end

    // R2: stop turns every switch off.
    a_r2_stop_off: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (hi_en == 3'b000 && lo_en == 3'b000));
    // R3: drive disable turns every switch off.
    a_r3_fault_off: assert property (@(posedge clk) disable iff (!rst_n)
        drv_off |=> (hi_en == 3'b000 && lo_en == 3'b000));
    // R7: brake drives all high sides, no low sides.
    a_r7_brake_all_high: assert property (@(posedge clk) disable iff (!rst_n)
        (brake && !stop && !drv_off) |=> (hi_en == 3'b111 && lo_en == 3'b000));
    // R8: without brake, a low carrier means no high side.
    a_r8_pwm_gates_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm && !brake) |=> (hi_en == 3'b000));
    // R9: a trip outside brake darkens the high side.
    a_r9_trip_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        (ilim_trip && !(brake && !stop && !drv_off)) |=> (hi_en == 3'b000));
    // R6: an all-equal Hall code while running gives no drive.
    a_r6_bad_code_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN && !dec_ok) |=> (hi_en == 3'b000 && lo_en == 3'b000));
    // R4: a legal code selects one source and one distinct sink phase.
    a_r4_decode_pair: assert property (@(posedge clk) disable iff (!rst_n)
        dec_ok |-> ($onehot(dec_hi) && $onehot(dec_lo) && (dec_hi & dec_lo) == 3'b000));
    // R11: no phase leg is shorted and at most one sink is on.
    a_r11_no_shoot: assert property (@(posedge clk) disable iff (!rst_n)
        ((hi_en & lo_en) == 3'b000) && $onehot0(lo_en));
endmodule

// File: tb/sim_bldc_commutator.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared against the ports every clock.
module sim_bldc_commutator;
    localparam int DEAD = 3;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] hall;
    logic       dir_rev, brake, stop, pwm, ilim_trip, drv_off;
    logic [2:0] hi_en, lo_en;

    always #2 clk = ~clk;

    bldc_commutator #(.DEAD_CYC(DEAD)) u0 (
        .clk(clk), .rst_n(rst_n), .hall(hall), .dir_rev(dir_rev),
        .brake(brake), .stop(stop), .pwm(pwm), .ilim_trip(ilim_trip),
        .drv_off(drv_off), .hi_en(hi_en), .lo_en(lo_en)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit chk_en = 0;
    logic [2:0] exp_hi = 3'b000;
    logic [2:0] exp_lo = 3'b000;
    string exp_tag = "R1";
    int age_m [3] = '{0, 0, 0};
    bit blank_m = 0;
    bit pwm_prev_m = 0;

    // Forward rotation order of Hall codes.
    logic [2:0] steps [6] = '{3'b001, 3'b011, 3'b010, 3'b110, 3'b100, 3'b101};

    function automatic int step_of(input logic [2:0] c);
        for (int i = 0; i < 6; i++)
            if (steps[i] == c) return i;
        return -1;
    endfunction

    // Reference model: next expected outputs from the inputs at this edge.
    always @(posedge clk) begin : model
        bit rise, effb, brk;
        logic [2:0] th, tl, code;
        int s;
        string tg;
        cycles++;
        if (!rst_n) begin
            exp_hi = 3'b000; exp_lo = 3'b000; exp_tag = "R1";
            for (int p = 0; p < 3; p++) age_m[p] = 0;
            blank_m = 0; pwm_prev_m = 0;
        end else begin
            rise = pwm && !pwm_prev_m;
            effb = ilim_trip || (blank_m && !rise);
            th = 3'b000; tl = 3'b000; brk = 0;
            if (drv_off) tg = "R3";
            else if (stop) tg = "R2";
            else if (brake) begin th = 3'b111; brk = 1; tg = "R7"; end
            else begin
                code = dir_rev ? ~hall : hall;
                s = step_of(code);
                if (s < 0) tg = "R6";
                else begin
                    th[s / 2] = 1'b1;
                    tl[((s + 1) / 2 + 1) % 3] = 1'b1;
                    tg = dir_rev ? "R5" : "R4";
                    if (!pwm) tg = "R8";
                    if (effb) tg = "R9";
                end
            end
            exp_hi = brk ? th : ((pwm && !effb) ? th : 3'b000);
            exp_lo = 3'b000;
            for (int p = 0; p < 3; p++) begin
                if (tl[p] && age_m[p] == 0) exp_lo[p] = 1'b1;
                else if (tl[p]) tg = "R10";
            end
            for (int p = 0; p < 3; p++)
                age_m[p] = th[p] ? DEAD : ((age_m[p] > 0) ? age_m[p] - 1 : 0);
            blank_m = effb;
            pwm_prev_m = pwm;
            exp_tag = tg;
        end
    end

    // Compare ports against the model away from the active edge; R11 checked too.
    always @(negedge clk) begin
        if (chk_en) begin
            checks++;
            if (hi_en !== exp_hi || lo_en !== exp_lo) begin
                errors++;
                $display("FAIL %s hi_en=%b lo_en=%b expected hi_en=%b lo_en=%b at cycle %0d",
                         exp_tag, hi_en, lo_en, exp_hi, exp_lo, cycles);
            end
            checks++;
            if ((hi_en & lo_en) != 3'b000) begin
                errors++;
                $display("FAIL R11 hi_en=%b lo_en=%b expected no shared phase", hi_en, lo_en);
            end
        end
    end

    // Watchdog: an overlong run counts as a failure.
    always @(posedge clk) begin
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog cycles=%0d expected under 20000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic drive(input logic [2:0] h, input logic dr, input logic bk,
                         input logic sp, input logic pw, input logic il,
                         input logic off, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            hall = h; dir_rev = dr; brake = bk; stop = sp;
            pwm = pw; ilim_trip = il; drv_off = off;
        end
    endtask

    initial begin
        rst_n = 1'b0; hall = 3'b000; dir_rev = 1'b1; brake = 1'b1; stop = 1'b1;
        pwm = 1'b0; ilim_trip = 1'b0; drv_off = 1'b0;
        repeat (2) @(negedge clk);
        chk_en = 1;                                  // R1: reset state checks
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        drive(3'b001, 0, 0, 1, 1, 0, 0, 3);          // R2: stopped
        // R4: forward walk with full carrier, dead time on each step (R10)
        for (int i = 0; i < 6; i++) drive(steps[i], 0, 0, 0, 1, 0, 0, 6);
        // R5: reverse walk
        for (int i = 5; i >= 0; i--) drive(steps[i], 1, 0, 0, 1, 0, 0, 6);
        // R8: chopped carrier
        for (int i = 0; i < 6; i++) begin
            drive(steps[i], 0, 0, 0, 1, 0, 0, 2);
            drive(steps[i], 0, 0, 0, 0, 0, 0, 2);
        end
        // R9: trip mid-pulse, blank held across the carrier until its next rise
        drive(3'b011, 0, 0, 0, 1, 0, 0, 2);
        drive(3'b011, 0, 0, 0, 1, 1, 0, 1);
        drive(3'b011, 0, 0, 0, 1, 0, 0, 3);
        drive(3'b011, 0, 0, 0, 0, 0, 0, 2);
        drive(3'b011, 0, 0, 0, 1, 0, 0, 3);
        // R6: all-equal codes in both directions
        drive(3'b000, 0, 0, 0, 1, 0, 0, 3);
        drive(3'b111, 0, 0, 0, 1, 0, 0, 3);
        drive(3'b111, 1, 0, 0, 1, 0, 0, 3);
        // R7: brake ignores carrier, trip and Hall code
        drive(3'b000, 0, 1, 0, 0, 1, 0, 4);
        // R10: release brake, sink phase waits out the dead time
        drive(3'b010, 0, 0, 0, 1, 0, 0, 6);
        // R3: fault disable wins over brake and run
        drive(3'b010, 0, 1, 0, 1, 0, 1, 3);
        drive(3'b010, 0, 0, 0, 1, 0, 1, 3);
        drive(3'b010, 0, 1, 1, 1, 0, 0, 3);          // R2: stop wins over brake
        // Mixed stimulus
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] r;
            r = 8'($urandom);
            drive(3'($urandom), r[0], (r[3:1] == 3'd0), (r[6:4] == 3'd0), r[7],
                  ($urandom % 11 == 0), ($urandom % 37 == 0), 1);
        end
        // R1: reset in mid-run
        drive(3'b001, 0, 0, 0, 1, 0, 0, 3);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        drive(3'b001, 0, 0, 0, 1, 0, 0, 4);
        @(negedge clk);
        chk_en = 0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule